// File: doc/BRIEF.md
# Multi-Format Signed Adder/Subtractor

This block adds or subtracts two signed operands held in one of three binary encodings for negative numbers. A two-bit format select picks the encoding on every cycle: sign-magnitude, ones complement or twos complement. A one-bit operation select picks A+B or A−B. The block returns the result in the same encoding as the operands, together with an overflow flag that applies that encoding's own rule. The operand width is a parameter, with 4 bits as the default.

Each encoding has its own datapath, and all three share one ripple-carry chain design. Sign-magnitude subtraction flips the sign of B. Operands with differing signs then go through a magnitude compare-and-subtract. Ones complement subtraction inverts B, and its sum gets the end-around carry. Twos complement subtraction inverts B and forces a carry-in of one. The selected result and flag are registered, so they appear one clock after the inputs are presented. Reset is synchronous and active low.

Top module: `addsub_multi`

## Requirements
- R1: While rst_n is low at a rising clock edge, the next outputs are res = 0 and ovf = 0, whatever the other inputs are.
- R2: res and ovf reflect the fmt, sub, a and b sampled at the previous rising clock edge at which rst_n was high.
- R3: The fmt encoding is as follows: 2'b00 selects sign-magnitude, 2'b01 selects ones complement, and 2'b10 and 2'b11 both select twos complement. sub = 0 selects A+B and sub = 1 selects A−B.
- R4: In twos complement, res equals (A ± B) modulo 2^W, where each operand has the value x − 2^W when its top bit is 1. This holds whether or not ovf is set.
- R5: In twos complement, ovf is 1 exactly when the true result lies outside [−2^(W−1), 2^(W−1)−1]. Adding two operands of opposite sign never overflows.
- R6: In ones complement, a negative value v is encoded as (2^W − 1) + v. When ovf is 0, res encodes the true result A ± B. A zero result may appear as either all zeros or all ones.
- R7: In ones complement, ovf is 1 exactly when the magnitude of the true result exceeds 2^(W−1)−1. Adding two operands of opposite sign never overflows.
- R8: In sign-magnitude, bit W−1 is the sign (1 means negative) and bits W−2:0 are the magnitude. When ovf is 0, res encodes the true result A ± B.
- R9: In sign-magnitude, ovf is 1 exactly when the magnitude of the true result exceeds 2^(W−1)−1. Operands whose effective signs differ never overflow.
- R10: In sign-magnitude, res is never negative zero. A zero magnitude always carries sign 0.
- R11: Negative-zero operands in sign-magnitude and ones complement are treated as the value zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fmt | input | 2 | Operand and result encoding select |
| sub | input | 1 | 0 selects A+B, 1 selects A−B |
| a | input | W | Operand A |
| b | input | W | Operand B |
| res | output | W | Registered result, in the selected encoding |
| ovf | output | 1 | Registered overflow flag, using the rule of the selected encoding |

## Verification
The bench builds the block with its default width of 4. At that width it is practical to apply every combination of format, operation and operand pair: 2048 vectors, including the redundant fourth format code. This covers every negative-zero operand, every equal-magnitude cancellation and the most negative twos complement value on both sides of the operator. It also covers each overflow edge, such as 5+3 and −7−2. A reference model decodes the operands to integers and derives the expected result and flag from the true arithmetic value. A reset applied in mid-run confirms that the registered outputs clear.

// File: rtl/addsub_pkg.sv
// Package: shared format encoding for the multi-format adder/subtractor.
// Assumes two select bits; the fourth code aliases twos complement.
package addsub_pkg;
    typedef enum logic [1:0] {
        FMT_SIGNMAG  = 2'b00,
        FMT_ONES     = 2'b01,
        FMT_TWOS     = 2'b10,
        FMT_TWOS_ALT = 2'b11
    } num_fmt_e;
endpackage

// File: rtl/addsub_ripple.sv
// Module: W-bit ripple-carry chain built from generate/propagate terms.
// Purely combinational; assumes W >= 1.
module addsub_ripple #(
    parameter int W = 4
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    logic [W:0] carry;

    assign carry[0] = cin;

    // One full-adder slice per bit position.
    for (genvar i = 0; i < W; i++) begin : g_slice
        logic gen_i;
        logic prop_i;
        assign gen_i        = x[i] & y[i];
        assign prop_i       = x[i] ^ y[i];
        assign sum[i]       = prop_i ^ carry[i];
        assign carry[i+1]   = gen_i | (prop_i & carry[i]);
    end

    assign cout = carry[W];
endmodule

// File: rtl/addsub_signmag.sv
// Module: sign-magnitude add/subtract. Subtraction flips B's sign; equal
// signs add magnitudes, differing signs subtract smaller from larger.
// Assumes W >= 2. Zero results are always given a positive sign.
module addsub_signmag #(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] res,
    output logic         ovf
);
    localparam int M = W - 1;

    logic         sgn_a;
    logic         sgn_b_eff;
    logic         differ;
    logic [M-1:0] mag_s;
    logic         mag_co;
    logic [M-1:0] mag_out;
    logic         sgn_out;

    assign sgn_a     = a[W-1];
    assign sgn_b_eff = b[W-1] ^ sub;
    assign differ    = sgn_a ^ sgn_b_eff;

    // Magnitude add, or magnitude subtract (ma + ~mb + 1) when signs differ.
    addsub_ripple #(.W(M)) u_mag (
        .x    (a[M-1:0]),
        .y    (b[M-1:0] ^ {M{differ}}),
        .cin  (differ),
        .sum  (mag_s),
        .cout (mag_co)
    );

    // Choose magnitude and sign; normalise zero to positive.
    always_comb begin
        ovf = 1'b0;
        if (!differ) begin
            mag_out = mag_s;
            sgn_out = sgn_a;
            ovf     = mag_co;
        end else if (mag_co) begin
            mag_out = mag_s;
            sgn_out = sgn_a;
        end else begin
            mag_out = ~mag_s + 1'b1;
            sgn_out = sgn_b_eff;
        end
        if (mag_out == '0) begin
            sgn_out = 1'b0;
        end
        res = {sgn_out, mag_out};
    end
endmodule

// File: rtl/addsub_ones.sv
// Module: ones complement add/subtract with end-around carry.
// Subtraction inverts B. Overflow: like-signed operands, unlike result.
module addsub_ones #(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] res,
    output logic         ovf
);
    logic [W-1:0] b_eff;
    logic [W-1:0] raw_sum;
    logic         raw_co;

    assign b_eff = b ^ {W{sub}};

    // First pass: plain unsigned addition.
    addsub_ripple #(.W(W)) u_add (
        .x    (a),
        .y    (b_eff),
        .cin  (1'b0),
        .sum  (raw_sum),
        .cout (raw_co)
    );

    // Fold the carry back in at bit 0 and judge the sign rule.
    always_comb begin
        res = raw_sum + {{(W-1){1'b0}}, raw_co};
        ovf = (a[W-1] == b_eff[W-1]) && (res[W-1] != a[W-1]);
    end
endmodule

// File: rtl/addsub_twos.sv
// Module: twos complement add/subtract, carry out discarded.
// Subtraction is A + ~B + 1; overflow is carry-in xor carry-out of the MSB.
module addsub_twos #(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] res,
    output logic         ovf
);
    logic [W-1:0] b_eff;
    logic         co;
    logic         c_into_msb;

    assign b_eff = b ^ {W{sub}};

    // Single pass with forced carry-in for subtraction.
    addsub_ripple #(.W(W)) u_add (
        .x    (a),
        .y    (b_eff),
        .cin  (sub),
        .sum  (res),
        .cout (co)
    );

    // Carry into the sign slice recovered from its sum bit.
    assign c_into_msb = a[W-1] ^ b_eff[W-1] ^ res[W-1];
    assign ovf        = c_into_msb ^ co;
endmodule

// File: rtl/addsub_multi.sv
// Module: top of the multi-format adder/subtractor. Runs all three
// encodings side by side, selects one by fmt and registers result and flag.
// Assumes W >= 2; synchronous active-low reset clears the outputs.
module addsub_multi
    import addsub_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   fmt,
    input  logic         sub,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] res,
    output logic         ovf
);
    logic [W-1:0] sm_res, oc_res, tc_res;
    logic         sm_ovf, oc_ovf, tc_ovf;
    logic [W-1:0] sel_res;
    logic         sel_ovf;

    addsub_signmag #(.W(W)) u_sm (
        .a(a), .b(b), .sub(sub), .res(sm_res), .ovf(sm_ovf)
    );
    addsub_ones #(.W(W)) u_oc (
        .a(a), .b(b), .sub(sub), .res(oc_res), .ovf(oc_ovf)
    );
    addsub_twos #(.W(W)) u_tc (
        .a(a), .b(b), .sub(sub), .res(tc_res), .ovf(tc_ovf)
    );

    // Pick the datapath named by the format select.
    always_comb begin
        case (num_fmt_e'(fmt))
            FMT_SIGNMAG: begin sel_res = sm_res; sel_ovf = sm_ovf; end
            FMT_ONES:    begin sel_res = oc_res; sel_ovf = oc_ovf; end
            default:     begin sel_res = tc_res; sel_ovf = tc_ovf; end
        endcase
    end

    // Output register with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res <= '0;
            ovf <= 1'b0;
        end else begin
            res <= sel_res;
            ovf <= sel_ovf;
        end
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (res == '0 && !ovf));

    // R2 and R4: 0 + B in twos complement returns B one cycle later.
    assert_one_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt[1] && !sub && a == '0) |=> (res == $past(b) && !ovf));

    assert_twos_mixed_no_ovf_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt[1] && !sub && (a[W-1] != b[W-1])) |=> !ovf);

    assert_ones_mixed_no_ovf_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt == FMT_ONES && !sub && (a[W-1] != b[W-1])) |=> !ovf);

    assert_sm_mixed_no_ovf_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt == FMT_SIGNMAG && (a[W-1] ^ b[W-1] ^ sub)) |=> !ovf);

    assert_sm_pos_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt == FMT_SIGNMAG) |=> !(res[W-1] && res[W-2:0] == '0));
endmodule

// File: tb/tb_addsub_multi.sv
// Scoreboard bench: driver pushes expected items, monitor pops and compares.
module tb_addsub_multi;
    localparam int W    = 4;
    localparam int FULL = 1 << W;
    localparam int HALF = 1 << (W - 1);

    typedef struct {
        logic [W-1:0] exp_res;
        logic         exp_ovf;
        logic         chk_res;
        logic         zero_alt;
        string        tag;
    } item_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   fmt = 2'b10;
    logic         sub = 1'b0;
    logic [W-1:0] a = '1;
    logic [W-1:0] b = '1;
    logic [W-1:0] res;
    logic         ovf;

    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    item_t sb_q[$];

    addsub_multi #(.W(W)) dut (
        .clk(clk), .rst_n(rst_n), .fmt(fmt), .sub(sub),
        .a(a), .b(b), .res(res), .ovf(ovf)
    );

    always #10 clk = ~clk;

    function automatic int decode(input int f, input int x);
        if (f == 0) return (x >= HALF) ? -(x - HALF) : x;
        if (f == 1) return (x >= HALF) ? x - (FULL - 1) : x;
        return (x >= HALF) ? x - FULL : x;
    endfunction

    task automatic check_reset(input string tag);
        checks++;
        if (res !== '0 || ovf !== 1'b0) begin
            errors++;
            $display("FAIL %s: res=%0d ovf=%0d expected res=0 ovf=0", tag, res, ovf);
        end
    endtask

    // Driver: apply one vector at the falling edge and queue its expectation.
    task automatic drive(input int f, input int s, input int x, input int y);
        item_t it;
        int    da, db, t;
        bit    neg_zero_in;
        da = decode(f, x);
        db = decode(f, y);
        t  = (s != 0) ? da - db : da + db;
        if (f >= 2) begin
            it.exp_ovf  = (t > HALF - 1) || (t < -HALF);
            it.exp_res  = W'(((t % FULL) + FULL) % FULL);
            it.chk_res  = 1'b1;
            it.zero_alt = 1'b0;
            it.tag      = (f == 3) ? "R3" : (it.exp_ovf ? "R5" : "R4");
        end else begin
            it.exp_ovf  = (t > HALF - 1) || (t < -(HALF - 1));
            it.chk_res  = !it.exp_ovf;
            it.zero_alt = (f == 1) && (t == 0);
            if (f == 0) it.exp_res = (t < 0) ? W'(HALF - t) : W'(t);
            else        it.exp_res = (t < 0) ? W'((FULL - 1) + t) : W'(t);
            neg_zero_in = (f == 0) ? (x == HALF || y == HALF)
                                   : (x == FULL - 1 || y == FULL - 1);
            if (neg_zero_in)       it.tag = "R11";
            else if (f == 0 && t == 0) it.tag = "R10";
            else if (f == 0)       it.tag = it.exp_ovf ? "R9" : "R8";
            else                   it.tag = it.exp_ovf ? "R7" : "R6";
        end
        @(negedge clk);
        fmt = 2'(f);
        sub = s[0];
        a   = W'(x);
        b   = W'(y);
        sb_q.push_back(it);
    endtask

    // Monitor: between edges, compare the registered outputs (R2 latency).
    initial begin
        item_t it;
        bit    ok;
        forever begin
            @(posedge clk);
            #5;
            if (sb_q.size() > 0) begin
                it = sb_q.pop_front();
                ok = (ovf === it.exp_ovf);
                if (it.chk_res) begin
                    if (it.zero_alt)
                        ok = ok && (res === '0 || res === '1);
                    else
                        ok = ok && (res === it.exp_res);
                end
                checks++;
                if (!ok) begin
                    errors++;
                    $display("FAIL %s R2: res=%0d ovf=%0d expected res=%0d ovf=%0d",
                             it.tag, res, ovf, it.exp_res, it.exp_ovf);
                end
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #5;
        check_reset("R1 initial reset");
        @(negedge clk);
        rst_n = 1'b1;
        for (int f = 0; f < 4; f++)
            for (int s = 0; s < 2; s++)
                for (int x = 0; x < FULL; x++)
                    for (int y = 0; y < FULL; y++)
                        drive(f, s, x, y);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b0;
        fmt = 2'b10; sub = 1'b0; a = W'(HALF - 1); b = W'(1);
        @(posedge clk);
        #5;
        check_reset("R1 mid-run reset");
        @(negedge clk);
        rst_n = 1'b1;
        drive(2, 0, 5, 3);
        drive(2, 1, FULL - 7, 2);
        repeat (3) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule